// File: doc/BRIEF.md
# Dual Latch-Loaded Interval Timers

This block holds two 16-bit down-counters for a general-purpose peripheral adapter. A bus-side decoder hands it single-cycle access strobes with a 4-bit register select. Each timer counts from a 16-bit latch. The low latch byte is written on its own. A write to the timer's high byte commits the latch into the counter and arms the timer.

Timer 1 runs either one-shot or free-running. It can drive an output pin whose level it sets on load, on timeout and on each reload. Timer 2 runs one-shot. It counts either clock-enable ticks or falling edges on an input pin.

Interrupt bookkeeping is kept outside this block. The block only emits one-cycle set and clear pulses per timer, and the interrupt aggregator turns them into flag bits. Mode bits arrive from a control register held elsewhere.

Accesses are plain strobes, not a stream. Every strobe is taken in its own cycle, and there is no back-pressure, so no ready signal exists. Read data is valid in the same cycle as `acc_rd`.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, every counter, latch and armed state is zero. Reads of selects 4 to 9 return 0, `pb7_out` is 0, and no set pulse is produced until a timer is loaded.
- R2: A write to select 4 or 6 (timer 1) or select 8 (timer 2) changes only the low byte of that timer's latch. The counter keeps its value.
- R3: A write to select 5 (timer 1) or select 9 (timer 2) does four things: it stores the byte as the latch high half, copies the whole latch into the counter, arms the timer, and pulses that timer's `flag_clr` in the next cycle. A load takes priority over a decrement in the same cycle.
- R4: A write to select 7 updates the timer 1 latch high half only. The counter is not reloaded and no clear pulse follows.
- R5: A counter steps down by one in each cycle with `tick_en` high. A timer that is armed, with a counter of zero on a decrement, pulses `flag_set` one cycle later. In one-shot mode the counter then wraps to 0xFFFF and no further set pulse occurs until the next load.
- R6: With `mode_ctl[6]` set, timer 1 runs free. A decrement at zero reloads the counter from the latch and produces a set pulse each time.
- R7: `pb7_oe` follows `mode_ctl[7]`. `pb7_out` goes low on a timer 1 load. It goes high at a one-shot timeout and toggles at each free-running reload.
- R8: With `mode_ctl[5]` set, timer 2 ignores `tick_en`. It decrements once for each falling edge of `pb6_in`, with the edge detected after a two-stage synchronizer.
- R9: While `acc_rd` is high, the block drives `acc_rdata` as follows: selects 4 and 5 give the timer 1 counter low and high bytes, 6 and 7 give the timer 1 latch low and high bytes, 8 and 9 give the timer 2 counter low and high bytes, and any other select gives 0. With `acc_rd` low, `acc_rdata` is 0.
- R10: A read of select 4 pulses `flag_clr[1]` and a read of select 8 pulses `flag_clr[0]`, each one cycle later. Index 1 is timer 1 (flag bit 6) and index 0 is timer 2 (flag bit 5).
- R11: If a set and a clear for the same timer fall due in one cycle, the set pulse is issued and the clear is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Clock-enable tick for counting |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe |
| acc_sel | input | 4 | Register select |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte |
| mode_ctl | input | 8 | Mode bits: 7 pin drive, 6 timer 1 free-run, 5 timer 2 pulse count |
| pb6_in | input | 1 | Pulse input for timer 2 |
| pb7_out | output | 1 | Timer 1 pin level |
| pb7_oe | output | 1 | Timer 1 pin drive enable |
| flag_set | output | 2 | Flag set pulses (1: timer 1, 0: timer 2) |
| flag_clr | output | 2 | Flag clear pulses (1: timer 1, 0: timer 2) |

## Verification
A timer can reach zero in the same cycle that its low counter byte is read, so a set and a read-clear for the same flag collide. The bench provokes this collision directly by loading timer 1 with 1 and issuing the read of select 4 exactly in the cycle the counter sits at zero. It then requires a set pulse with no clear. Random traffic with small load values makes the same collision, and the one between a load and a decrement at zero, recur many times. Each cycle is judged against a cycle-accurate model built from the requirements.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    SEL_T1_CNT_LO = 4'd4,
    SEL_T1_CNT_HI = 4'd5,
    SEL_T1_LAT_LO = 4'd6,
    SEL_T1_LAT_HI = 4'd7,
    SEL_T2_CNT_LO = 4'd8,
    SEL_T2_CNT_HI = 4'd9
  } tsel_e;

  localparam int CTL_PIN_DRIVE = 7;
  localparam int CTL_T1_FREE   = 6;
  localparam int CTL_T2_PULSE  = 5;

  localparam int IDX_T1 = 1;
  localparam int IDX_T2 = 0;
  localparam int N_TMR  = 2;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sq;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq   <= '0;
      last <= 1'b0;
    end else begin
      sq   <= {sq[STAGES-2:0], pin};
      last <= sq[STAGES-1];
    end
  end

  assign fall = last & ~sq[STAGES-1];
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic          load,
  input  logic [BW-1:0] wdata,
  input  logic          dec,
  input  logic          free_run,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] latch,
  output logic          fire
);
  logic armed;

  assign fire = dec & ~load & armed & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      latch <= '0;
      armed <= 1'b0;
    end else begin
      if (wr_lo)
        latch[BW-1:0] <= wdata;
      if (wr_hi || load)
        latch[CW-1:BW] <= wdata;
      if (load) begin
        cnt   <= {wdata, latch[BW-1:0]};
        armed <= 1'b1;
      end else if (dec) begin
        if (cnt == '0) begin
          cnt <= free_run ? latch : '1;
          if (!free_run)
            armed <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [3:0]        acc_sel,
  input  logic [BYTE_W-1:0] acc_wdata,
  output logic [BYTE_W-1:0] acc_rdata,
  input  logic [7:0]        mode_ctl,
  input  logic              pb6_in,
  output logic              pb7_out,
  output logic              pb7_oe,
  output logic [1:0]        flag_set,
  output logic [1:0]        flag_clr
);
  localparam int CW = 2 * BYTE_W;

  logic [N_TMR-1:0] wr_lo, wr_hi, load, rd_clr, dec, free_run, fire;
  logic [CW-1:0]    cnt   [N_TMR];
  logic [CW-1:0]    latch [N_TMR];
  logic             pb6_fall;

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (pb6_in),
    .fall (pb6_fall)
  );

  // Per-timer access decode
  always_comb begin
    wr_lo[IDX_T1]    = acc_wr && (acc_sel == SEL_T1_CNT_LO || acc_sel == SEL_T1_LAT_LO);
    wr_hi[IDX_T1]    = acc_wr && (acc_sel == SEL_T1_LAT_HI);
    load[IDX_T1]     = acc_wr && (acc_sel == SEL_T1_CNT_HI);
    rd_clr[IDX_T1]   = acc_rd && (acc_sel == SEL_T1_CNT_LO);
    dec[IDX_T1]      = tick_en;
    free_run[IDX_T1] = mode_ctl[CTL_T1_FREE];

    wr_lo[IDX_T2]    = acc_wr && (acc_sel == SEL_T2_CNT_LO);
    wr_hi[IDX_T2]    = 1'b0;
    load[IDX_T2]     = acc_wr && (acc_sel == SEL_T2_CNT_HI);
    rd_clr[IDX_T2]   = acc_rd && (acc_sel == SEL_T2_CNT_LO);
    dec[IDX_T2]      = mode_ctl[CTL_T2_PULSE] ? pb6_fall : tick_en;
    free_run[IDX_T2] = 1'b0;
  end

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    tmr_core #(.BW(BYTE_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (wr_lo[g]),
      .wr_hi   (wr_hi[g]),
      .load    (load[g]),
      .wdata   (acc_wdata),
      .dec     (dec[g]),
      .free_run(free_run[g]),
      .cnt     (cnt[g]),
      .latch   (latch[g]),
      .fire    (fire[g])
    );
  end

  // Flag pulses: a set outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_set <= '0;
      flag_clr <= '0;
    end else begin
      flag_set <= fire;
      flag_clr <= (load | rd_clr) & ~fire;
    end
  end

  // Timer 1 pin level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pb7_out <= 1'b0;
    else if (load[IDX_T1])
      pb7_out <= 1'b0;
    else if (fire[IDX_T1])
      pb7_out <= free_run[IDX_T1] ? ~pb7_out : 1'b1;
  end

  assign pb7_oe = mode_ctl[CTL_PIN_DRIVE];

  always_comb begin
    acc_rdata = '0;
    if (acc_rd) begin
      unique case (acc_sel)
        SEL_T1_CNT_LO: acc_rdata = cnt[IDX_T1][BYTE_W-1:0];
        SEL_T1_CNT_HI: acc_rdata = cnt[IDX_T1][CW-1:BYTE_W];
        SEL_T1_LAT_LO: acc_rdata = latch[IDX_T1][BYTE_W-1:0];
        SEL_T1_LAT_HI: acc_rdata = latch[IDX_T1][CW-1:BYTE_W];
        SEL_T2_CNT_LO: acc_rdata = cnt[IDX_T2][BYTE_W-1:0];
        SEL_T2_CNT_HI: acc_rdata = cnt[IDX_T2][CW-1:BYTE_W];
        default:       acc_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dit_checker.sv
module dit_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic       acc_wr,
  input logic       acc_rd,
  input logic [3:0] acc_sel,
  input logic [7:0] acc_wdata,
  input logic [7:0] acc_rdata,
  input logic [7:0] mode_ctl,
  input logic       pb6_in,
  input logic       pb7_out,
  input logic       pb7_oe,
  input logic [1:0] flag_set,
  input logic [1:0] flag_clr
);
  AST_LOAD_CLEARS_T1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_sel == 4'd5) |=> (flag_clr[1] && !flag_set[1])); // R3

  AST_LATCH_HI_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_sel == 4'd7) |=> !flag_clr[1]); // R4

  AST_PIN_LOW_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_sel == 4'd5) |=> !pb7_out); // R7

  AST_READ_CLEARS_T2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_sel == 4'd8) |=> (flag_clr[0] || flag_set[0])); // R10

  AST_SET_CLR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set & flag_clr) == 2'b00); // R11

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |-> acc_rdata == 8'h00); // R9
endmodule

bind dual_interval_timer dit_checker u_chk (.*);

// File: tb/sim_dual_interval_timer.sv
module sim_dual_interval_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       acc_wr = 1'b0;
  logic       acc_rd = 1'b0;
  logic [3:0] acc_sel = 4'd0;
  logic [7:0] acc_wdata = 8'd0;
  logic [7:0] acc_rdata;
  logic [7:0] mode_ctl = 8'd0;
  logic       pb6_in = 1'b1;
  logic       pb7_out, pb7_oe;
  logic [1:0] flag_set, flag_clr;

  int n_vec = 0;
  int n_bad = 0;
  bit scb_on = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_interval_timer u0 (.*);

  // Reference model built from the requirements
  logic [15:0] m_cnt [2];
  logic [15:0] m_lat [2];
  logic [1:0]  m_arm, m_set, m_clr;
  logic        m_pb7, m_sq1, m_sq2, m_last;

  function automatic logic mload(int i);
    return acc_wr && acc_sel == ((i == 1) ? 4'd5 : 4'd9);
  endfunction
  function automatic logic mwrlo(int i);
    return acc_wr && ((i == 1) ? (acc_sel == 4'd4 || acc_sel == 4'd6) : (acc_sel == 4'd8));
  endfunction
  function automatic logic mwrhi(int i);
    return (i == 1) && acc_wr && acc_sel == 4'd7;
  endfunction
  function automatic logic mfree(int i);
    return (i == 1) && mode_ctl[6];
  endfunction
  function automatic logic mdec(int i);
    if (i == 1) return tick_en;
    return mode_ctl[5] ? (m_last && !m_sq2) : tick_en;
  endfunction
  function automatic logic mfire(int i);
    return mdec(i) && !mload(i) && m_arm[i] && m_cnt[i] == 16'h0;
  endfunction
  function automatic logic mrdclr(int i);
    return acc_rd && acc_sel == ((i == 1) ? 4'd4 : 4'd8);
  endfunction
  function automatic logic [7:0] exp_rd();
    if (!acc_rd) return 8'h00;
    case (acc_sel)
      4'd4: return m_cnt[1][7:0];
      4'd5: return m_cnt[1][15:8];
      4'd6: return m_lat[1][7:0];
      4'd7: return m_lat[1][15:8];
      4'd8: return m_cnt[0][7:0];
      4'd9: return m_cnt[0][15:8];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] <= 16'h0;
        m_lat[i] <= 16'h0;
      end
      m_arm <= 2'b0; m_set <= 2'b0; m_clr <= 2'b0;
      m_pb7 <= 1'b0; m_sq1 <= 1'b0; m_sq2 <= 1'b0; m_last <= 1'b0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (mwrlo(i)) m_lat[i][7:0] <= acc_wdata;
        if (mwrhi(i) || mload(i)) m_lat[i][15:8] <= acc_wdata;
        if (mload(i)) begin
          m_cnt[i] <= {acc_wdata, m_lat[i][7:0]};
          m_arm[i] <= 1'b1;
        end else if (mdec(i)) begin
          if (m_cnt[i] == 16'h0) begin
            m_cnt[i] <= mfree(i) ? m_lat[i] : 16'hFFFF;
            if (!mfree(i)) m_arm[i] <= 1'b0;
          end else begin
            m_cnt[i] <= m_cnt[i] - 16'd1;
          end
        end
        m_set[i] <= mfire(i);
        m_clr[i] <= (mload(i) || mrdclr(i)) && !mfire(i);
      end
      if (mload(1)) m_pb7 <= 1'b0;
      else if (mfire(1)) m_pb7 <= mfree(1) ? ~m_pb7 : 1'b1;
      m_sq1 <= pb6_in; m_sq2 <= m_sq1; m_last <= m_sq2;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle scoreboard
  always @(negedge clk) begin
    #2;
    if (rst_n && scb_on) begin
      check("R9 rdata", int'(acc_rdata), int'(exp_rd()));
      check("R5 flag_set", int'(flag_set), int'(m_set));
      check("R10 flag_clr", int'(flag_clr), int'(m_clr));
      check("R7 pb7_out", int'(pb7_out), int'(m_pb7));
      check("R7 pb7_oe", int'(pb7_oe), int'(mode_ctl[7]));
    end
  end

  task automatic cyc(bit wr, bit rd, logic [3:0] sel, logic [7:0] d);
    @(negedge clk);
    acc_wr = wr; acc_rd = rd; acc_sel = sel; acc_wdata = d;
  endtask
  task automatic idle();
    cyc(1'b0, 1'b0, 4'd0, 8'd0);
  endtask
  task automatic rd_check(string tag, logic [3:0] sel, logic [7:0] exp);
    cyc(1'b0, 1'b1, sel, 8'd0);
    #3 check(tag, int'(acc_rdata), int'(exp));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int first_set, n_set;
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    scb_on = 1'b1;

    // R1: reset state
    for (int s = 4; s <= 9; s++) rd_check("R1 read after reset", 4'(s), 8'h00);
    check("R1 pb7 after reset", int'(pb7_out), 0);
    tick_en = 1'b1;
    repeat (5) begin idle(); #3 check("R1 no set", int'(flag_set), 0); end
    tick_en = 1'b0;

    // R2, R3, R4 with counting stopped
    cyc(1'b1, 1'b0, 4'd6, 8'h34);
    cyc(1'b1, 1'b0, 4'd5, 8'h12);
    cyc(1'b1, 1'b0, 4'd4, 8'h55);
    rd_check("R2 counter low kept", 4'd4, 8'h34);
    rd_check("R2 latch low updated", 4'd6, 8'h55);
    rd_check("R3 counter high loaded", 4'd5, 8'h12);
    cyc(1'b1, 1'b0, 4'd7, 8'hAB);
    rd_check("R4 counter high unchanged", 4'd5, 8'h12);
    check("R4 no clear after latch-high write", int'(flag_clr[1]), 0);
    rd_check("R4 latch high updated", 4'd7, 8'hAB);
    cyc(1'b1, 1'b0, 4'd5, 8'h00);
    rd_check("R3 counter takes whole latch", 4'd4, 8'h55);
    check("R3 clear after load", int'(flag_clr[1]), 1);

    // R10: read of timer 2 low counter clears its flag
    cyc(1'b0, 1'b1, 4'd8, 8'h00);
    idle(); #3 check("R10 timer 2 read clear", int'(flag_clr[0]), 1);

    // R5, R7: one-shot timeout
    mode_ctl = 8'h80;
    cyc(1'b1, 1'b0, 4'd6, 8'h03);
    cyc(1'b1, 1'b0, 4'd5, 8'h00);
    tick_en = 1'b1;
    first_set = 0; n_set = 0;
    for (int n = 1; n <= 30; n++) begin
      idle(); #3;
      if (n == 1) check("R7 pin low after load", int'(pb7_out), 0);
      if (flag_set[1]) begin n_set++; if (first_set == 0) first_set = n; end
    end
    check("R5 set delay", first_set, 5);
    check("R5 one-shot single set", n_set, 1);
    check("R7 pin high after timeout", int'(pb7_out), 1);

    // R6: free-running with latch 2
    mode_ctl = 8'hC0;
    cyc(1'b1, 1'b0, 4'd6, 8'h02);
    cyc(1'b1, 1'b0, 4'd5, 8'h00);
    n_set = 0;
    for (int n = 1; n <= 31; n++) begin
      idle(); #3;
      if (flag_set[1]) n_set++;
    end
    check("R6 free-run set count", n_set, 10);
    check("R7 pin after ten toggles", int'(pb7_out), 0);

    // R8: pulse counting on timer 2
    mode_ctl = 8'h20;
    cyc(1'b1, 1'b0, 4'd8, 8'h05);
    cyc(1'b1, 1'b0, 4'd9, 8'h00);
    repeat (3) begin
      pb6_in = 1'b0; repeat (4) idle();
      pb6_in = 1'b1; repeat (4) idle();
    end
    rd_check("R8 counted three edges", 4'd8, 8'h02);
    rd_check("R8 high byte", 4'd9, 8'h00);

    // R11: read-clear collides with a timeout
    mode_ctl = 8'h00;
    tick_en = 1'b1;
    cyc(1'b1, 1'b0, 4'd6, 8'h01);
    cyc(1'b1, 1'b0, 4'd5, 8'h00);
    idle();
    cyc(1'b0, 1'b1, 4'd4, 8'h00);
    idle(); #3;
    check("R11 set wins", int'(flag_set[1]), 1);
    check("R11 clear dropped", int'(flag_clr[1]), 0);

    // Random traffic against the model
    for (int k = 0; k < 6000; k++) begin
      int r;
      logic [3:0] s;
      r = int'($urandom % 10);
      s = ($urandom % 8 == 0) ? 4'($urandom) : 4'(4 + $urandom % 6);
      @(negedge clk);
      acc_wr = (r < 3); acc_rd = (r >= 3 && r < 6);
      acc_sel = s;
      acc_wdata = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 4);
      tick_en = ($urandom % 4 != 0);
      if ($urandom % 3 == 0) pb6_in = ~pb6_in;
      if ($urandom % 200 == 0) mode_ctl = 8'($urandom) & 8'hE0;
    end
    idle();
    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule